// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog Timer

This block is a watchdog for a system-on-chip. Its register port runs on the peripheral clock. Its timing counter runs on a separate, free-running oscillator clock. Software first programs a 12-bit period value and then enables the timer. After that, software must service the timer from time to time by writing a clear bit. If one full period passes without service, the block raises an interrupt. If a second period passes back to back without service, the block drives a reset request that stays high until the block itself is reset. Software can also request a reset immediately by forcing a parity-error event.

The enable command and the counter-restart command reach the oscillator domain through a toggle handshake. A busy bit stays set until the oscillator side has acknowledged the command. The service clear does not use this handshake. It drops the interrupt on the next peripheral clock and restarts the count over a plain two-flop path. The period register is locked while the timer is enabled. The oscillator side latches the period only when it goes from disabled to enabled.

Top module: `ovfWatchdog`

## Requirements
- R1: After the asynchronous reset, the interrupt and the reset output are low, and every readable register returns zero.
- R2: The period register at byte offset 0x04 stores only write-data bits 31:20, as the value N. Bits 19:0 always read back as zero.
- R3: A write to the period register while the timer is enabled (control offset 0x00, bit 0 = 1) is ignored. A period written while disabled takes effect at the next enable.
- R4: With the timer enabled and no service, the interrupt (also read at offset 0x0C bit 0) rises one period after the enable lands. One period is (N+1)·2^PRE_W oscillator cycles, plus the crossing latency.
- R5: A second overflow in a row without service sets the reset output. It also sets the watchdog-cause bit at offset 0x0C bit 1.
- R6: Writing 1 to offset 0x0C bit 0 clears the interrupt by the next peripheral clock edge and restarts the count. A timer that is serviced within each period never raises the interrupt or the reset.
- R7: Writing the value 0 to offset 0x08 restarts the running count from zero, so the next overflow lies a full period after that write.
- R8: A write to the control register sets the busy bit (offset 0x00 bit 1) in the next cycle. The busy bit clears once the oscillator side has taken the command. The enable bit then reads back at offset 0x00 bit 0.
- R9: Writing 1 to offset 0x14 bit 0 while offset 0x10 bit 0 is 0 sets the reset output in the next cycle and sets the parity flag (offset 0x14 bit 0). With offset 0x10 bit 0 at 1, the same write has no effect.
- R10: Once set, the reset output stays high, even through service writes, until the asynchronous reset is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Peripheral clock for the register port and the overflow tracking |
| oscClk | input | 1 | Oscillator clock for the prescaled counter |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| regWe | input | 1 | Register write strobe, sampled on pclk |
| regAddr | input | 5 | Byte offset of the register access |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr (combinational) |
| irqOut | output | 1 | Interrupt after the first unserviced overflow |
| wdtRstOut | output | 1 | Sticky reset request |

## Verification
The main timing is run over a table of period values (0, 1, 2 and 3). The same check points, scaled per value, separate a correct period formula from an off-by-one in the prescale or period compare. Each vector samples just before and just after both the first and the second overflow, which separates a single-stage watchdog from a two-stage one. Serviced and unserviced runs tell a working clear path from one that only drops the interrupt without restarting the count. A counter-initialise write in mid-period and a period write during a run each move the overflow time in a way that exposes a missing restart or a missing lock. Parity forcing is run with the parity control at 1 and at 0 to show the gate.

// File: rtl/owdPkg.sv
package owdPkg;
  localparam int ADDR_W   = 5;
  localparam int PERIOD_W = 12;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_PERIOD = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_INIT   = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_CLEAR  = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_PEC    = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_PEF    = 5'h14;

  // strobes and quasi-static payload from the peripheral-side control
  // to the oscillator-side counter
  typedef struct packed {
    logic                reqTog;
    logic                clrTog;
    logic                cmdIsEn;
    logic                cmdEnVal;
    logic [PERIOD_W-1:0] period;
  } xferT;
endpackage

// File: rtl/owdSync.sv
module owdSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owdCtrl.sv
module owdCtrl
  import owdPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              ackTog,
  input  logic              ovfTog,
  output xferT              xfer,
  output logic              busy,
  output logic              irqOut,
  output logic              rstOut
);
  localparam int PLSB = DATA_W - PERIOD_W;

  logic ackSync, ovfSync, ovfSeen, ovfEvt;
  logic enShadow, pecBit, parErr, wdCause, irqFlag;
  logic wrCtrl, wrPeriod, wrInit, wrClr, wrPec, wrPef;

  owdSync #(.STAGES(2)) ackSync_i (.clk(pclk), .rstN(rstN), .d(ackTog), .q(ackSync));
  owdSync #(.STAGES(2)) ovfSync_i (.clk(pclk), .rstN(rstN), .d(ovfTog), .q(ovfSync));

  assign busy     = xfer.reqTog ^ ackSync;
  assign ovfEvt   = ovfSync ^ ovfSeen;
  assign wrCtrl   = regWe && (regAddr == ADR_CTRL);
  assign wrPeriod = regWe && (regAddr == ADR_PERIOD);
  assign wrInit   = regWe && (regAddr == ADR_INIT) && (regWdata == '0);
  assign wrClr    = regWe && (regAddr == ADR_CLEAR) && regWdata[0];
  assign wrPec    = regWe && (regAddr == ADR_PEC);
  assign wrPef    = regWe && (regAddr == ADR_PEF) && regWdata[0];

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      xfer     <= '0;
      enShadow <= 1'b0;
      pecBit   <= 1'b0;
      parErr   <= 1'b0;
      wdCause  <= 1'b0;
      irqFlag  <= 1'b0;
      rstOut   <= 1'b0;
      ovfSeen  <= 1'b0;
    end else begin
      ovfSeen <= ovfSync;
      // commands that need the handshake; dropped while one is in flight
      if (wrCtrl && !busy) begin
        enShadow      <= regWdata[0];
        xfer.cmdIsEn  <= 1'b1;
        xfer.cmdEnVal <= regWdata[0];
        xfer.reqTog   <= ~xfer.reqTog;
      end else if (wrInit && !busy) begin
        xfer.cmdIsEn <= 1'b0;
        xfer.reqTog  <= ~xfer.reqTog;
      end
      if (wrPeriod && !enShadow) xfer.period <= regWdata[DATA_W-1:PLSB];
      if (wrPec) pecBit <= regWdata[0];
      // two-stage overflow tracking; service wins over a same-cycle overflow
      if (wrClr) begin
        irqFlag     <= 1'b0;
        xfer.clrTog <= ~xfer.clrTog;
      end else if (ovfEvt) begin
        if (irqFlag) begin
          rstOut  <= 1'b1;
          wdCause <= 1'b1;
        end else begin
          irqFlag <= 1'b1;
        end
      end
      if (wrPef && !pecBit) begin
        rstOut <= 1'b1;
        parErr <= 1'b1;
      end
    end
  end

  assign irqOut = irqFlag;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADR_CTRL:   regRdata = {{(DATA_W-2){1'b0}}, busy, enShadow};
      ADR_PERIOD: regRdata = {xfer.period, {PLSB{1'b0}}};
      ADR_CLEAR:  regRdata = {{(DATA_W-2){1'b0}}, wdCause, irqFlag};
      ADR_PEC:    regRdata = {{(DATA_W-1){1'b0}}, pecBit};
      ADR_PEF:    regRdata = {{(DATA_W-1){1'b0}}, parErr};
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/owdCount.sv
module owdCount
  import owdPkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic oscClk,
  input  logic rstN,
  input  xferT xfer,
  output logic ackTog,
  output logic ovfTog
);
  logic reqSync, clrSync, reqSeen, clrSeen, reqEvt, clrEvt;
  logic enOsc;
  logic [PERIOD_W-1:0] periodLat, hiCnt;
  logic [PRE_W-1:0]    loCnt;

  owdSync #(.STAGES(2)) reqSync_i (.clk(oscClk), .rstN(rstN), .d(xfer.reqTog), .q(reqSync));
  owdSync #(.STAGES(2)) clrSync_i (.clk(oscClk), .rstN(rstN), .d(xfer.clrTog), .q(clrSync));

  assign reqEvt = reqSync ^ reqSeen;
  assign clrEvt = clrSync ^ clrSeen;

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      reqSeen   <= 1'b0;
      clrSeen   <= 1'b0;
      ackTog    <= 1'b0;
      ovfTog    <= 1'b0;
      enOsc     <= 1'b0;
      periodLat <= '0;
      loCnt     <= '0;
      hiCnt     <= '0;
    end else begin
      reqSeen <= reqSync;
      clrSeen <= clrSync;
      if (reqEvt) begin
        ackTog <= ~ackTog;
        if (xfer.cmdIsEn) begin
          if (xfer.cmdEnVal && !enOsc) periodLat <= xfer.period;
          enOsc <= xfer.cmdEnVal;
        end
      end
      if (!enOsc || clrEvt || (reqEvt && !xfer.cmdIsEn)) begin
        loCnt <= '0;
        hiCnt <= '0;
      end else begin
        loCnt <= loCnt + 1'b1;
        if (&loCnt) begin
          if (hiCnt == periodLat) begin
            hiCnt  <= '0;
            ovfTog <= ~ovfTog;
          end else begin
            hiCnt <= hiCnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ovfWatchdog.sv
module ovfWatchdog
  import owdPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 20
) (
  input  logic              pclk,
  input  logic              oscClk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic              wdtRstOut
);
  xferT xfer;
  logic ackTog, ovfTog, busy;

  owdCtrl #(.DATA_W(DATA_W)) ctrl_i (
    .pclk(pclk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ackTog(ackTog),
    .ovfTog(ovfTog), .xfer(xfer), .busy(busy), .irqOut(irqOut),
    .rstOut(wdtRstOut)
  );

  owdCount #(.PRE_W(PRE_W)) count_i (
    .oscClk(oscClk), .rstN(rstN), .xfer(xfer), .ackTog(ackTog), .ovfTog(ovfTog)
  );
endmodule

// File: rtl/owdChecker.sv
module owdChecker
  import owdPkg::*;
#(
  parameter int LOW_W = 20
) (
  input logic              pclk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wdata0,
  input logic [LOW_W-1:0]  rdataLow,
  input logic              irqOut,
  input logic              wdtRstOut,
  input logic              busy
);
  logic pecSh;

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) pecSh <= 1'b0;
    else if (regWe && regAddr == ADR_PEC) pecSh <= wdata0;
  end

  AST_PERIOD_LOW_ZERO: assert property (@(posedge pclk) disable iff (!rstN)
    (regAddr == ADR_PERIOD) |-> (rdataLow == '0)); // R2

  AST_RST_NEEDS_CAUSE: assert property (@(posedge pclk) disable iff (!rstN)
    $rose(wdtRstOut) |-> ($past(irqOut) || $past(regWe && regAddr == ADR_PEF && wdata0))); // R5

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge pclk) disable iff (!rstN)
    (regWe && regAddr == ADR_CLEAR && wdata0) |=> !irqOut); // R6

  AST_BUSY_ON_CMD: assert property (@(posedge pclk) disable iff (!rstN)
    (regWe && regAddr == ADR_CTRL && !busy) |=> busy); // R8

  AST_PARITY_FIRES: assert property (@(posedge pclk) disable iff (!rstN)
    (regWe && regAddr == ADR_PEF && wdata0 && !pecSh) |=> wdtRstOut); // R9

  AST_RST_STICKY: assert property (@(posedge pclk) disable iff (!rstN)
    wdtRstOut |=> wdtRstOut); // R10
endmodule

bind ovfWatchdog owdChecker #(.LOW_W(DATA_W - owdPkg::PERIOD_W)) chk_i (
  .pclk(pclk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .wdata0(regWdata[0]), .rdataLow(regRdata[DATA_W-owdPkg::PERIOD_W-1:0]),
  .irqOut(irqOut), .wdtRstOut(wdtRstOut), .busy(busy)
);

// File: tb/ovfWatchdog_tb.sv
module ovfWatchdog_tb_top;
  import owdPkg::*;

  localparam int DATA_W  = 32;
  localparam int PRE_W   = 4;
  localparam int OSC_NS  = 30;
  localparam int PCLK_NS = 20;
  localparam logic [PERIOD_W-1:0] VEC_N [4] = '{12'd0, 12'd1, 12'd3, 12'd2};

  logic pclk = 1'b0;
  logic oscClk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic irqOut, wdtRstOut;
  logic [DATA_W-1:0] rv;
  int checks = 0;
  int errors = 0;

  always #(PCLK_NS/2) pclk = ~pclk;
  always #(OSC_NS/2) oscClk = ~oscClk;

  ovfWatchdog #(.DATA_W(DATA_W), .PRE_W(PRE_W)) dut_i (
    .pclk(pclk), .oscClk(oscClk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .wdtRstOut(wdtRstOut)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge pclk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge pclk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    regAddr = a;
    #1;
    rv = regRdata;
  endtask

  task automatic waitBusy();
    for (int i = 0; i < 100; i++) begin
      rd(ADR_CTRL);
      if (!rv[1]) break;
      cyc(1);
    end
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc(2);
  endtask

  function automatic int periodNs(input logic [PERIOD_W-1:0] n);
    return (int'(n) + 1) * (1 << PRE_W) * OSC_NS;
  endfunction

  initial begin
    repeat (200000) @(posedge pclk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    resetDut();
    chk("R1 irq", irqOut, 0);
    chk("R1 rst", wdtRstOut, 0);
    rd(ADR_CTRL);   chk("R1 ctrl", rv, 0);
    rd(ADR_PERIOD); chk("R1 period", rv, 0);
    rd(ADR_CLEAR);  chk("R1 status", rv, 0);
    rd(ADR_PEF);    chk("R1 parity", rv, 0);

    // R2 period field masking
    wr(ADR_PERIOD, 32'hFFFF_FFFF);
    rd(ADR_PERIOD); chk("R2 mask", rv, 32'hFFF0_0000);

    // table of periods: first and second overflow timing
    for (int v = 0; v < 4; v++) begin
      int t, lo1, hi1, lo2, hi2;
      resetDut();
      wr(ADR_PERIOD, {VEC_N[v], 20'h0});
      wr(ADR_CTRL, 1);
      t   = periodNs(VEC_N[v]);
      lo1 = (t + 50) / PCLK_NS;
      hi1 = (t + 300) / PCLK_NS;
      lo2 = (2 * t + 50) / PCLK_NS;
      hi2 = (2 * t + 300) / PCLK_NS;
      cyc(lo1);       chk("R4 irq early", irqOut, 0);
      cyc(hi1 - lo1); chk("R4 irq set", irqOut, 1);
      cyc(lo2 - hi1); chk("R5 rst early", wdtRstOut, 0);
      cyc(hi2 - lo2); chk("R5 rst set", wdtRstOut, 1);
      rd(ADR_CLEAR);  chk("R5 cause", rv[1:0], 2'b11);
    end

    // R3 period locked while enabled, applied at re-enable
    resetDut();
    wr(ADR_PERIOD, 32'h0010_0000);
    wr(ADR_CTRL, 1);
    waitBusy();
    wr(ADR_PERIOD, 32'h0050_0000);
    rd(ADR_PERIOD); chk("R3 locked", rv, 32'h0010_0000);
    wr(ADR_CTRL, 0);
    waitBusy();
    wr(ADR_CLEAR, 1);
    wr(ADR_PERIOD, 32'h0050_0000);
    rd(ADR_PERIOD); chk("R3 unlocked", rv, 32'h0050_0000);
    wr(ADR_CTRL, 1);
    cyc(75);  chk("R3 new period not early", irqOut, 0);
    cyc(84);  chk("R3 new period fires", irqOut, 1);

    // R6 service keeps the timer quiet; clear restarts the sequence
    resetDut();
    wr(ADR_PERIOD, 32'h0010_0000);
    wr(ADR_CTRL, 1);
    waitBusy();
    for (int i = 0; i < 10; i++) begin
      cyc(30);
      wr(ADR_CLEAR, 1);
    end
    chk("R6 serviced irq", irqOut, 0);
    chk("R6 serviced rst", wdtRstOut, 0);
    cyc(63);  chk("R4 unserviced irq", irqOut, 1);
    wr(ADR_CLEAR, 1);
    chk("R6 clear drops irq", irqOut, 0);
    cyc(50);
    chk("R6 restart irq", irqOut, 0);
    chk("R6 restart rst", wdtRstOut, 0);
    cyc(15);
    chk("R6 next irq", irqOut, 1);
    chk("R6 next no rst", wdtRstOut, 0);

    // R7 counter initialise and R8 busy handshake
    resetDut();
    wr(ADR_PERIOD, 32'h0010_0000);
    wr(ADR_CTRL, 1);
    rd(ADR_CTRL); chk("R8 busy set", rv[1], 1);
    cyc(35);
    rd(ADR_CTRL); chk("R8 landed", rv[1:0], 2'b01);
    wr(ADR_INIT, 0);
    cyc(49);  chk("R7 restarted", irqOut, 0);
    cyc(14);  chk("R7 fires after init", irqOut, 1);

    // R9 parity forcing, R10 sticky reset
    resetDut();
    wr(ADR_PEC, 1);
    wr(ADR_PEF, 1);
    chk("R9 gated rst", wdtRstOut, 0);
    rd(ADR_PEF); chk("R9 gated flag", rv, 0);
    wr(ADR_PEC, 0);
    wr(ADR_PEF, 1);
    chk("R9 forced rst", wdtRstOut, 1);
    rd(ADR_PEF);   chk("R9 flag", rv, 1);
    rd(ADR_CLEAR); chk("R9 no wdt cause", rv[1], 0);
    cyc(100);
    wr(ADR_CLEAR, 1);
    chk("R10 sticky", wdtRstOut, 1);
    rstN = 1'b0;
    cyc(2);
    chk("R10 released", wdtRstOut, 0);
    rstN = 1'b1;
    cyc(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule